// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block moves one 16-bit sample word, presented on a parallel input, across a three-wire source-synchronous link: a bit clock, a frame-sync strobe and a serial data line. A host starts a transfer by pulling its read strobe low while chip select is low and the converter core reports that it is idle. For the length of the transfer the block raises a busy flag, enables its link drivers and produces the bit clock at half the system clock rate. At all other times the link drivers are disabled, which stands in for high impedance.

The sync strobe marks word boundaries, and each data bit lags the strobe by one bit period. The receiver can therefore shift on falling bit-clock edges and take the finished word on the second rising edge after a sync pulse. A mode input chooses between a single 16-bit word and two 8-bit bytes per transfer. The block samples the mode input and the sample word when the transfer starts. Raising chip select in the middle of a transfer stops it at once.

Bit slots are counted from 1. Slot k begins on the k-th rising edge of the bit clock in the transfer. Slot 1 begins on the first system clock after the start edge.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no transfer is running, `busy`, `link_oe`, `link_clk`, `link_sync` and `link_data` are all 0.
- R2: A transfer starts on a clock edge that meets all of these conditions: `rd_n` is sampled low, `rd_n` was sampled high on the edge before, `cs_n` is low, `conv_idle` is high and no transfer is running. From the next cycle `busy` and `link_oe` are 1.
- R3: A falling `rd_n` starts nothing when `cs_n` is high or `conv_idle` is low.
- R4: During a transfer `link_clk` is high in the first cycle and then toggles every system cycle, giving 17 bit periods. Each bit period is one cycle high followed by one cycle low, and each rising edge starts a new slot.
- R5: In word mode (`byte_mode` = 0 at start), `link_sync` is high for the whole of slots 1 and 17 and low in all other slots.
- R6: `link_data` is 0 in slot 1. Slots 2 through 17 carry sample bits 15 down to 0, most significant bit first.
- R7: In byte mode (`byte_mode` = 1 at start), `link_sync` is high in slots 1, 9 and 17. The data order is the same as in R6, so bit 8 is in slot 9 and bit 0 is in slot 17.
- R8: A transfer that is not aborted lasts exactly 34 cycles. On the clock after the low half of slot 17, `busy` and `link_oe` return to 0.
- R9: A falling `rd_n` seen while a transfer is running is ignored, including one in the final cycle of the transfer.
- R10: If `cs_n` is sampled high during a transfer, the next cycle is idle as in R1. The link stays idle until a new qualified read starts.
- R11: Changes on `byte_mode` or `sample_word` after the start edge do not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low; its falling edge requests a transfer |
| cs_n | input | 1 | Chip select, active low; high aborts a transfer |
| conv_idle | input | 1 | Converter core is in a wait or sample phase |
| byte_mode | input | 1 | 0: one 16-bit word, 1: two 8-bit bytes |
| sample_word | input | 16 | Sample word to send |
| busy | output | 1 | Transfer in progress |
| link_clk | output | 1 | Bit clock, half the system rate |
| link_sync | output | 1 | Frame-sync strobe |
| link_data | output | 1 | Serial data, MSB first |
| link_oe | output | 1 | Driver enable for sync and data; 0 means high impedance |

## Verification
Two events can land on the same clock edge: the close of a transfer after slot 17, and a new falling edge on `rd_n`. The bench places a read-strobe fall exactly on the closing edge. It judges the result against a cycle model that keeps the request ignored, so the link must go idle and stay idle. A second collision puts a chip-select rise partway through a frame. Any slot emitted after that edge counts as a mismatch.

// File: rtl/ssf_pkg.sv
// Shared definitions for the framed serial sample transmitter.
// Assumes word and byte lengths are powers of two.
package ssf_pkg;
    localparam int SSF_WORD_W = 16;
    localparam int SSF_BYTE_W = 8;

    // Bundle of link-side outputs produced inside the top module.
    typedef struct packed {
        logic busy;
        logic clk;
        logic sync;
        logic data;
        logic oe;
    } ssf_link_t;
endpackage

// File: rtl/ssf_req_qual.sv
// Read request qualifier: turns a falling read strobe into a one-cycle
// start pulse. Assumes rd_n is already synchronous to clk.
module ssf_req_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic cs_n,
    input  logic conv_idle,
    input  logic active,
    output logic start
);
    logic rd_q;

    // Keep the previous read strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    // Start only on a fresh falling edge, selected, core idle, link free.
    assign start = rd_q & ~rd_n & ~cs_n & conv_idle & ~active;
endmodule

// File: rtl/ssf_slot_timer.sv
// Slot timer: counts half bit periods for one transfer, makes the bit
// clock and the slot index, and ends the transfer on completion or abort.
// Assumes start is never asserted while active is high.
module ssf_slot_timer #(
    parameter int WORD_W = 16,
    localparam int HALF_N = 2 * WORD_W + 2,
    localparam int CNT_W  = $clog2(HALF_N),
    localparam int SLOT_W = CNT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    output logic              active,
    output logic              bit_clk,
    output logic [SLOT_W-1:0] slot,
    output logic              shift_en
);
    localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(HALF_N - 1);
    localparam logic [CNT_W-1:0] FIRST_SHIFT = CNT_W'(3);

    logic [CNT_W-1:0] tick;

    // Run the half-period counter from start until the last tick or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tick   <= '0;
        end else if (start) begin
            active <= 1'b1;
            tick   <= '0;
        end else if (active) begin
            if (abort || tick == LAST_TICK) begin
                active <= 1'b0;
                tick   <= '0;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // Bit clock is high in the even half of each slot.
    assign bit_clk  = active & ~tick[0];
    assign slot     = tick[CNT_W-1:1];
    // Advance the data bit when leaving the low half of slot 2 or later.
    assign shift_en = active & tick[0] & (tick >= FIRST_SHIFT);
endmodule

// File: rtl/ssf_shift_out.sv
// Output shifter: holds the word and mode taken at start, presents bits
// MSB first one slot behind the sync strobe, and decodes sync slots.
// Assumes BYTE_W and WORD_W are powers of two with BYTE_W <= WORD_W.
module ssf_shift_out #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift_en,
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] word_in,
    input  logic              byte_in,
    output logic              sync,
    output logic              data
);
    localparam logic [SLOT_W-1:0] BYTE_MASK = SLOT_W'(BYTE_W - 1);
    localparam logic [SLOT_W-1:0] WORD_MASK = SLOT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic              byte_q;

    // Capture word and mode at start, then shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            byte_q <= 1'b0;
        end else if (start) begin
            shreg  <= word_in;
            byte_q <= byte_in;
        end else if (shift_en) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    logic on_boundary;

    // A slot is a sync slot when it sits on a frame-length boundary.
    always_comb begin
        if (byte_q) on_boundary = (slot & BYTE_MASK) == '0;
        else        on_boundary = (slot & WORD_MASK) == '0;
    end

    assign sync = active & on_boundary;
    assign data = active & (slot != '0) & shreg[WORD_W-1];
endmodule

// File: rtl/serial_frame_tx.sv
// Framed serial sample transmitter top: qualifies read requests, times
// the bit slots and serialises the captured sample word onto a
// clock/sync/data link with a driver enable standing in for tri-state.
// Assumes all inputs are synchronous to clk.
module serial_frame_tx
    import ssf_pkg::*;
#(
    parameter int WORD_W = SSF_WORD_W,
    parameter int BYTE_W = SSF_BYTE_W,
    localparam int SLOT_W = $clog2(2 * WORD_W + 2) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              cs_n,
    input  logic              conv_idle,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] sample_word,
    output logic              busy,
    output logic              link_clk,
    output logic              link_sync,
    output logic              link_data,
    output logic              link_oe
);
    logic              start;
    logic              active;
    logic              bit_clk;
    logic              shift_en;
    logic [SLOT_W-1:0] slot;
    logic              sync_w;
    logic              data_w;
    ssf_link_t         link;

    ssf_req_qual u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n      (rd_n),
        .cs_n      (cs_n),
        .conv_idle (conv_idle),
        .active    (active),
        .start     (start)
    );

    ssf_slot_timer #(.WORD_W(WORD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (cs_n),
        .active   (active),
        .bit_clk  (bit_clk),
        .slot     (slot),
        .shift_en (shift_en)
    );

    ssf_shift_out #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .SLOT_W(SLOT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shift_en (shift_en),
        .active   (active),
        .slot     (slot),
        .word_in  (sample_word),
        .byte_in  (byte_mode),
        .sync     (sync_w),
        .data     (data_w)
    );

    // Gather the link outputs; enables follow the transfer state.
    always_comb begin
        link.busy = active;
        link.clk  = bit_clk;
        link.sync = sync_w;
        link.data = data_w;
        link.oe   = active;
    end

    assign busy      = link.busy;
    assign link_clk  = link.clk;
    assign link_sync = link.sync;
    assign link_data = link.data;
    assign link_oe   = link.oe;
endmodule

// File: rtl/ssf_link_chk.sv
// Protocol checker for serial_frame_tx, attached by bind. Observes the
// ports only and assumes a synchronous active-low reset.
module ssf_link_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_n,
    input logic cs_n,
    input logic conv_idle,
    input logic busy,
    input logic link_clk,
    input logic link_sync,
    input logic link_data,
    input logic link_oe
);
    // Idle link is fully quiet.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!link_oe && !link_clk && !link_sync && !link_data));

    // A transfer begins only after a selected, idle-core read request.
    assert_start_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(!cs_n) && $past(conv_idle) && $past(!rd_n)));

    // Bit clock alternates every cycle while a transfer continues.
    assert_clk_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (link_clk != $past(link_clk)));

    // First slot: clock high, sync high, data low, drivers on.
    assert_first_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (link_sync && link_clk && !link_data && link_oe));

    // Chip select high during a transfer idles the link next cycle.
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_n) |=> (!busy && !link_oe));
endmodule

bind serial_frame_tx ssf_link_chk i_chk (.*);

// File: tb/test_serial_frame_tx.sv
// Bench for serial_frame_tx: a behavioural cycle model predicts every
// output and is compared at each falling clock edge.
module test_serial_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        conv_idle = 1'b1;
    logic        byte_mode = 1'b0;
    logic [15:0] sample_word = 16'h0;
    logic        busy, link_clk, link_sync, link_data, link_oe;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // Model state.
    bit        m_busy = 0;
    bit        m_prev = 1;
    int        m_n = 0;
    bit [15:0] m_word = 0;
    bit        m_byte = 0;

    serial_frame_tx i_serial_frame_tx (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .cs_n(cs_n),
        .conv_idle(conv_idle), .byte_mode(byte_mode),
        .sample_word(sample_word), .busy(busy), .link_clk(link_clk),
        .link_sync(link_sync), .link_data(link_data), .link_oe(link_oe)
    );

    always #2 clk = ~clk;

    // Behavioural model advanced on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_prev = 1; m_n = 0;
        end else begin
            if (m_busy) begin
                if (cs_n || m_n == 33) m_busy = 0;
                else m_n = m_n + 1;
            end else if (m_prev && !rd_n && !cs_n && conv_idle) begin
                m_busy = 1; m_n = 0;
                m_word = sample_word; m_byte = byte_mode;
            end
            m_prev = rd_n;
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n || cur_req == "R1") begin
            bit [4:0] exp_v;
            bit [4:0] got_v;
            exp_v = 5'b0;
            if (m_busy && rst_n) begin
                int s;
                s = m_n / 2;
                exp_v[4] = 1'b1;
                exp_v[3] = (m_n % 2) == 0;
                exp_v[2] = m_byte ? (s % 8 == 0) : (s % 16 == 0);
                exp_v[1] = (s >= 1) ? m_word[16 - s] : 1'b0;
                exp_v[0] = 1'b1;
            end
            got_v = {busy, link_clk, link_sync, link_data, link_oe};
            n_tests++;
            if (got_v !== exp_v) begin
                n_fail++;
                $display("FAIL %s t=%0t busy/clk/sync/data/oe got %b expected %b",
                         cur_req, $time, got_v, exp_v);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL R8 watchdog expired got busy=%b expected 0", busy);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_n = 1'b0;
        @(negedge clk) rd_n = 1'b1;
    endtask

    initial begin
        // R1: reset and idle state.
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(3);

        // R2 R4 R5 R6 R8: word-mode transfer.
        cur_req = "R2 R4 R5 R6 R8";
        cs_n = 1'b0;
        sample_word = 16'hA5C3;
        do_read();
        wait_cyc(40);

        // R3: unqualified read strobes.
        cur_req = "R3";
        cs_n = 1'b1;
        do_read();
        wait_cyc(5);
        cs_n = 1'b0;
        conv_idle = 1'b0;
        do_read();
        wait_cyc(5);
        conv_idle = 1'b1;

        // R7: byte-mode transfer.
        cur_req = "R7";
        byte_mode = 1'b1;
        sample_word = 16'h3C96;
        do_read();
        wait_cyc(40);

        // R11: inputs change mid-transfer.
        cur_req = "R11";
        byte_mode = 1'b0;
        sample_word = 16'hF00F;
        do_read();
        wait_cyc(6);
        byte_mode = 1'b1;
        sample_word = 16'h1234;
        wait_cyc(40);

        // R9: read strobe falls mid-frame and on the closing edge.
        cur_req = "R9";
        byte_mode = 1'b0;
        sample_word = 16'h8001;
        @(negedge clk) rd_n = 1'b0;
        @(negedge clk) rd_n = 1'b1;
        wait_cyc(10);
        rd_n = 1'b0;
        wait_cyc(1);
        rd_n = 1'b1;
        wait_cyc(22);
        rd_n = 1'b0;
        wait_cyc(5);
        rd_n = 1'b1;
        wait_cyc(3);
        do_read();
        wait_cyc(40);

        // R10: chip-select abort, then a fresh read.
        cur_req = "R10";
        sample_word = 16'h7E81;
        do_read();
        wait_cyc(12);
        cs_n = 1'b1;
        wait_cyc(6);
        cs_n = 1'b0;
        wait_cyc(4);
        do_read();
        wait_cyc(40);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule